// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two floating-point operands and records a single true/false outcome in one selectable condition bit of a 32-bit floating-point status register that the block holds itself. The operands can be 32-bit single, 64-bit double, or a pair of 32-bit singles packed into 64 bits. A relation code picks the test: equal, less-than, or less-or-equal. Two mode inputs decide what happens with NaNs. The first chooses the constant written when the operands are unordered. The second chooses whether a quiet NaN raises the invalid-operation indication, in which case the condition bit is left alone.

A request is a one-cycle `start` strobe carrying all operands and modes. On the following clock edge the register holds the new value and `done` is high for one cycle. In the paired format the two 32-bit halves are treated as independent lanes. The lower half writes the selected condition bit and the upper half writes the next one. Each lane does its own NaN handling and its own write suppression.

Top module: `fp_cmp_cond`

## Requirements
- R1: After reset the status register reads zero and `done` is low.
- R2: A `start` sampled at a clock edge updates `status` at that edge and raises `done` for exactly one cycle; without `start` the register does not change and `done` stays low.
- R3: Condition index 0 selects status bit 23 and index k (1..7) selects status bit 24+k; every other status bit keeps its value, and a bit can be written back to 0.
- R4: Relation code 0 tests a == b, 1 tests a < b, 2 tests a <= b, and 3 always yields 0.
- R5: Ordered comparison is signed: +0 equals -0, any negative non-zero value is below any positive value, and of two negatives the larger magnitude is the smaller.
- R6: Format code 0 (and 3) compares the low 32 bits as singles, ignoring the upper 32 bits; code 1 compares all 64 bits as a double, so NaN detection uses an 11-bit exponent and 52-bit fraction there and an 8-bit exponent and 23-bit fraction for singles.
- R7: A NaN (exponent all ones, fraction non-zero) in either operand makes the result equal to `unord_true`, whatever the relation; infinities are ordered.
- R8: A NaN whose fraction MSB is 0 is quiet; with `quiet_trap` high and a quiet NaN in either operand, status bits 16 and 6 are set and the condition bit is left unchanged. A NaN with fraction MSB 1 never raises this indication.
- R9: Format code 2 compares bits 31:0 of both operands into the bit of `cc_idx` and bits 63:32 into the bit of `cc_idx+1` (wrapping 7 to 0), each half with its own relation result.
- R10: In format code 2 a quiet-NaN trap in one half suppresses only that half's condition write; the other half still writes.
- R11: Once set, status bits 16 and 6 stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| fmt | input | 2 | Operand format: 0 single, 1 double, 2 paired single, 3 single |
| rel | input | 2 | Relation: 0 equal, 1 less, 2 less-or-equal, 3 never |
| unord_true | input | 1 | Result used for unordered operands |
| quiet_trap | input | 1 | Quiet NaN raises invalid and blocks the write |
| cc_idx | input | 3 | Condition-code index |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| status | output | 32 | Floating-point status register |
| done | output | 1 | Completion pulse, one cycle after `start` |

## Verification
The two paired lanes can land in the same cycle with different outcomes: one half traps on a quiet NaN and sets the invalid bits, while the other half writes its condition bit. Vectors put a quiet NaN in only the upper half, then only the lower half, with `quiet_trap` high. The whole register is compared after each one, so it must show the invalid bits together with exactly the surviving lane's bit. A wrapping case with index 7, where the upper half lands on bit 23, checks the lane-to-bit mapping at the register's ends.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

   typedef enum logic [1:0] {
      FMT_SGL  = 2'd0,
      FMT_DBL  = 2'd1,
      FMT_PAIR = 2'd2,
      FMT_ALT  = 2'd3
   } fpcc_fmt_e;

   typedef enum logic [1:0] {
      REL_EQ   = 2'd0,
      REL_LT   = 2'd1,
      REL_LE   = 2'd2,
      REL_NONE = 2'd3
   } fpcc_rel_e;

   // raw relation of one operand pair
   typedef struct packed {
      logic unord;
      logic quiet;
      logic eq;
      logic lt;
   } fpcc_cmp_t;

   // resolved outcome of one lane
   typedef struct packed {
      logic trap;
      logic cond;
   } fpcc_lane_t;

endpackage

// File: rtl/fpcc_cmp.sv
module fpcc_cmp
   import fpcc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   output fpcc_cmp_t             res
);
   localparam int W   = 1 + EXP_W + FRAC_W;
   localparam int MAG = W - 1;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fields
      $error("fpcc_cmp: exponent and fraction need at least 2 bits");
   end

   logic             sign_a, sign_b;
   logic [MAG-1:0]   mag_a, mag_b;
   logic             nan_a, nan_b, qui_a, qui_b;
   logic             zeros;

   always_comb begin
      sign_a = a[W-1];
      sign_b = b[W-1];
      mag_a  = a[MAG-1:0];
      mag_b  = b[MAG-1:0];
      nan_a  = (&a[W-2 -: EXP_W]) && (|a[FRAC_W-1:0]);
      nan_b  = (&b[W-2 -: EXP_W]) && (|b[FRAC_W-1:0]);
      qui_a  = nan_a && !a[FRAC_W-1];
      qui_b  = nan_b && !b[FRAC_W-1];
      zeros  = (mag_a == '0) && (mag_b == '0);

      res.unord = nan_a || nan_b;
      res.quiet = qui_a || qui_b;
      res.eq    = zeros || (a == b);
      if (zeros)
         res.lt = 1'b0;
      else if (sign_a != sign_b)
         res.lt = sign_a;
      else if (!sign_a)
         res.lt = mag_a < mag_b;
      else
         res.lt = mag_a > mag_b;
   end
endmodule

// File: rtl/fpcc_resolve.sv
module fpcc_resolve
   import fpcc_pkg::*;
(
   input  fpcc_cmp_t  cmp,
   input  logic [1:0] rel,
   input  logic       unord_true,
   input  logic       quiet_trap,
   output fpcc_lane_t lane
);
   logic ordered_res;

   always_comb begin
      unique case (fpcc_rel_e'(rel))
         REL_EQ:  ordered_res = cmp.eq;
         REL_LT:  ordered_res = cmp.lt;
         REL_LE:  ordered_res = cmp.lt || cmp.eq;
         default: ordered_res = 1'b0;
      endcase
      lane.trap = quiet_trap && cmp.quiet;
      lane.cond = cmp.unord ? unord_true : ordered_res;
   end
endmodule

// File: rtl/fpcc_sr_update.sv
module fpcc_sr_update
   import fpcc_pkg::*;
#(
   parameter int SR_W      = 32,
   parameter int CC_IDX_W  = 3,
   parameter int CC_POS0   = 23,
   parameter int CC_BASE   = 24,
   parameter int INV_CAUSE = 16,
   parameter int INV_FLAG  = 6
) (
   input  logic [SR_W-1:0]     sr_in,
   input  fpcc_lane_t          lane_lo,
   input  fpcc_lane_t          lane_hi,
   input  logic                hi_en,
   input  logic [CC_IDX_W-1:0] idx_lo,
   input  logic [CC_IDX_W-1:0] idx_hi,
   output logic [SR_W-1:0]     sr_out
);
   function automatic int cc_pos(input logic [CC_IDX_W-1:0] k);
      return (k == '0) ? CC_POS0 : CC_BASE + int'(k);
   endfunction

   always_comb begin
      sr_out = sr_in;
      if (lane_lo.trap) begin
         sr_out[INV_CAUSE] = 1'b1;
         sr_out[INV_FLAG]  = 1'b1;
      end else begin
         sr_out[cc_pos(idx_lo)] = lane_lo.cond;
      end
      if (hi_en) begin
         if (lane_hi.trap) begin
            sr_out[INV_CAUSE] = 1'b1;
            sr_out[INV_FLAG]  = 1'b1;
         end else begin
            sr_out[cc_pos(idx_hi)] = lane_hi.cond;
         end
      end
   end
endmodule

// File: rtl/fp_cmp_cond.sv
module fp_cmp_cond
   import fpcc_pkg::*;
#(
   parameter int SR_W      = 32,
   parameter int CC_IDX_W  = 3,
   parameter int CC_POS0   = 23,
   parameter int CC_BASE   = 24,
   parameter int INV_CAUSE = 16,
   parameter int INV_FLAG  = 6,
   parameter bit PAIRED_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          fmt,
   input  logic [1:0]          rel,
   input  logic                unord_true,
   input  logic                quiet_trap,
   input  logic [CC_IDX_W-1:0] cc_idx,
   input  logic [63:0]         opnd_a,
   input  logic [63:0]         opnd_b,
   output logic [SR_W-1:0]     status,
   output logic                done
);
   localparam int NLANE  = PAIRED_EN ? 2 : 1;
   localparam int CC_TOP = CC_BASE + (1 << CC_IDX_W) - 1;

   if (CC_IDX_W < 1 || CC_TOP >= SR_W || CC_POS0 >= SR_W) begin : g_bad_cc
      $error("fp_cmp_cond: condition bits fall outside the status register");
   end
   if (INV_CAUSE >= SR_W || INV_FLAG >= SR_W || INV_CAUSE == INV_FLAG) begin : g_bad_inv
      $error("fp_cmp_cond: invalid-operation bit positions are not usable");
   end

   fpcc_cmp_t       cmp_s [NLANE];
   fpcc_cmp_t       cmp_d;
   fpcc_cmp_t       cmp_lo;
   fpcc_lane_t      lane_lo, lane_hi;
   logic            is_dbl, hi_en;
   logic [SR_W-1:0] sr_next;

   for (genvar i = 0; i < NLANE; i++) begin : g_sgl
      fpcc_cmp #(.EXP_W(8), .FRAC_W(23)) u_cmp (
         .a   (opnd_a[32*i +: 32]),
         .b   (opnd_b[32*i +: 32]),
         .res (cmp_s[i])
      );
   end

   fpcc_cmp #(.EXP_W(11), .FRAC_W(52)) u_cmp_dbl (
      .a   (opnd_a),
      .b   (opnd_b),
      .res (cmp_d)
   );

   assign is_dbl = (fpcc_fmt_e'(fmt) == FMT_DBL);
   assign cmp_lo = is_dbl ? cmp_d : cmp_s[0];

   fpcc_resolve u_res_lo (
      .cmp        (cmp_lo),
      .rel        (rel),
      .unord_true (unord_true),
      .quiet_trap (quiet_trap),
      .lane       (lane_lo)
   );

   if (PAIRED_EN) begin : g_pair
      fpcc_resolve u_res_hi (
         .cmp        (cmp_s[NLANE-1]),
         .rel        (rel),
         .unord_true (unord_true),
         .quiet_trap (quiet_trap),
         .lane       (lane_hi)
      );
      assign hi_en = (fpcc_fmt_e'(fmt) == FMT_PAIR);
   end else begin : g_solo
      assign lane_hi = '0;
      assign hi_en   = 1'b0;
   end

   fpcc_sr_update #(
      .SR_W      (SR_W),
      .CC_IDX_W  (CC_IDX_W),
      .CC_POS0   (CC_POS0),
      .CC_BASE   (CC_BASE),
      .INV_CAUSE (INV_CAUSE),
      .INV_FLAG  (INV_FLAG)
   ) u_sr (
      .sr_in   (status),
      .lane_lo (lane_lo),
      .lane_hi (lane_hi),
      .hi_en   (hi_en),
      .idx_lo  (cc_idx),
      .idx_hi  (cc_idx + 1'b1),
      .sr_out  (sr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         done   <= 1'b0;
      end else begin
         done <= start;
         if (start)
            status <= sr_next;
      end
   end
endmodule

// File: rtl/fpcc_check.sv
module fpcc_check #(
   parameter int SR_W      = 32,
   parameter int CC_IDX_W  = 3,
   parameter int CC_POS0   = 23,
   parameter int CC_BASE   = 24,
   parameter int INV_CAUSE = 16,
   parameter int INV_FLAG  = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [1:0]      fmt,
   input logic            quiet_trap,
   input logic [SR_W-1:0] status,
   input logic            done
);
   function automatic logic [SR_W-1:0] cc_mask();
      logic [SR_W-1:0] m;
      m = '0;
      m[CC_POS0] = 1'b1;
      for (int k = 1; k < (1 << CC_IDX_W); k++)
         m[CC_BASE + k] = 1'b1;
      return m;
   endfunction

   localparam logic [SR_W-1:0] CCM = cc_mask();
   localparam logic [SR_W-1:0] INVM = (SR_W'(1) << INV_CAUSE) | (SR_W'(1) << INV_FLAG);

   a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(status));
   a_r11_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status[INV_FLAG] |=> status[INV_FLAG]);
   a_r8_no_trap_no_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !quiet_trap) |=> ($stable(status[INV_CAUSE]) && $stable(status[INV_FLAG])));
   a_r3_foreign_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~(CCM | INVM)) == '0);
   a_r6_one_cc_unpaired: assert property (@(posedge clk) disable iff (!rst_n)
      (start && fmt != 2'd2) |=> $countones((status ^ $past(status)) & CCM) <= 1);
   a_r9_two_cc_paired: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> $countones((status ^ $past(status)) & CCM) <= 2);
endmodule

bind fp_cmp_cond fpcc_check #(
   .SR_W      (SR_W),
   .CC_IDX_W  (CC_IDX_W),
   .CC_POS0   (CC_POS0),
   .CC_BASE   (CC_BASE),
   .INV_CAUSE (INV_CAUSE),
   .INV_FLAG  (INV_FLAG)
) u_fpcc_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .fmt        (fmt),
   .quiet_trap (quiet_trap),
   .status     (status),
   .done       (done)
);

// File: tb/fp_cmp_cond_test.sv
module fp_cmp_cond_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  fmt = '0;
   logic [1:0]  rel = '0;
   logic        unord_true = 1'b0;
   logic        quiet_trap = 1'b0;
   logic [2:0]  cc_idx = '0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [31:0] status;
   logic        done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fp_cmp_cond uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .rel(rel),
      .unord_true(unord_true), .quiet_trap(quiet_trap), .cc_idx(cc_idx),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .status(status), .done(done)
   );

   // singles
   localparam logic [31:0] S1 = 32'h3F80_0000, S2 = 32'h4000_0000;
   localparam logic [31:0] SM1 = 32'hBF80_0000, SM2 = 32'hC000_0000;
   localparam logic [31:0] SPZ = 32'h0000_0000, SMZ = 32'h8000_0000;
   localparam logic [31:0] SQN = 32'h7F80_0001, SSN = 32'h7FC0_0000;
   // doubles
   localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
   localparam logic [63:0] DM2 = 64'hC000_0000_0000_0000, DQN = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] DINF = 64'h7FF0_0000_0000_0000;
   localparam logic [31:0] INV = 32'h0001_0040;

   // {fmt, rel, unord_true, quiet_trap, cc_idx, a, b, expected status from reset}
   localparam int NV = 26;
   localparam logic [168:0] VEC [NV] = '{
      {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, {32'h0, S1},  {32'h0, S1},  32'h0080_0000}, // R4 eq
      {2'd0, 2'd1, 1'b0, 1'b0, 3'd1, {32'h0, S1},  {32'h0, S2},  32'h0200_0000}, // R4 lt
      {2'd0, 2'd1, 1'b0, 1'b0, 3'd1, {32'h0, S2},  {32'h0, S1},  32'h0000_0000}, // R4 lt false
      {2'd0, 2'd2, 1'b0, 1'b0, 3'd2, {32'h0, S1},  {32'h0, S1},  32'h0400_0000}, // R4 le
      {2'd0, 2'd2, 1'b0, 1'b0, 3'd7, {32'h0, SM1}, {32'h0, S1},  32'h8000_0000}, // R5 sign
      {2'd0, 2'd1, 1'b0, 1'b0, 3'd3, {32'h0, S1},  {32'h0, SM1}, 32'h0000_0000}, // R5 sign
      {2'd0, 2'd0, 1'b0, 1'b0, 3'd4, {32'h0, SPZ}, {32'h0, SMZ}, 32'h1000_0000}, // R5 zeros
      {2'd0, 2'd1, 1'b0, 1'b0, 3'd5, {32'h0, SM2}, {32'h0, SM1}, 32'h2000_0000}, // R5 negatives
      {2'd0, 2'd3, 1'b1, 1'b0, 3'd6, {32'h0, S1},  {32'h0, S1},  32'h0000_0000}, // R4 never
      {2'd1, 2'd1, 1'b0, 1'b0, 3'd0, D1,           D2,           32'h0080_0000}, // R6 double
      {2'd1, 2'd0, 1'b0, 1'b0, 3'd3, DM2,          DM2,          32'h0800_0000}, // R6 double
      {2'd0, 2'd0, 1'b0, 1'b0, 3'd1, {32'hFFFF_FFFF, S1}, {32'h0, S1}, 32'h0200_0000}, // R6 upper ignored
      {2'd3, 2'd0, 1'b0, 1'b0, 3'd1, {32'hFFFF_FFFF, S1}, {32'h0, S1}, 32'h0200_0000}, // R6 code 3
      {2'd1, 2'd0, 1'b0, 1'b1, 3'd0, {32'h3FF0_0000, SQN}, {32'h3FF0_0000, SQN}, 32'h0080_0000}, // R6 width
      {2'd0, 2'd0, 1'b1, 1'b1, 3'd2, {32'h0, SSN}, {32'h0, S1},  32'h0400_0000}, // R7 signaling
      {2'd0, 2'd2, 1'b0, 1'b0, 3'd2, {32'h0, S1},  {32'h0, SSN}, 32'h0000_0000}, // R7 false
      {2'd0, 2'd0, 1'b1, 1'b1, 3'd0, {32'h0, SQN}, {32'h0, S1},  INV},           // R8 trap
      {2'd0, 2'd0, 1'b1, 1'b0, 3'd0, {32'h0, SQN}, {32'h0, S1},  32'h0080_0000}, // R8 no trap
      {2'd1, 2'd1, 1'b0, 1'b1, 3'd0, D1,           DQN,          INV},           // R8 double
      {2'd1, 2'd0, 1'b0, 1'b1, 3'd1, DINF,         DINF,         32'h0200_0000}, // R7 inf ordered
      {2'd2, 2'd1, 1'b0, 1'b0, 3'd0, {S2, S1},     {S1, S2},     32'h0080_0000}, // R9 low
      {2'd2, 2'd1, 1'b0, 1'b0, 3'd0, {S1, S2},     {S2, S1},     32'h0200_0000}, // R9 high
      {2'd2, 2'd1, 1'b0, 1'b0, 3'd7, {S1, S2},     {S2, S1},     32'h0080_0000}, // R9 wrap
      {2'd2, 2'd0, 1'b0, 1'b1, 3'd2, {SQN, S1},    {S1, S1},     32'h0401_0040}, // R10 high trap
      {2'd2, 2'd0, 1'b0, 1'b1, 3'd2, {S1, SQN},    {S1, S1},     32'h0801_0040}, // R10 low trap
      {2'd2, 2'd0, 1'b1, 1'b1, 3'd4, {S1, SSN},    {S2, S1},     32'h1000_0000}  // R9 mixed
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive at a falling edge, result visible at the next falling edge
   task automatic issue(input logic [1:0] f, input logic [1:0] r, input logic ut, input logic qt,
                        input logic [2:0] cc, input logic [63:0] a, input logic [63:0] b);
      fmt = f; rel = r; unord_true = ut; quiet_trap = qt; cc_idx = cc;
      opnd_a = a; opnd_b = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(status == 32'h0 && !done, "R1 reset", status, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [168:0] v;
         v = VEC[i];
         do_reset();
         @(negedge clk);
         issue(v[168:167], v[166:165], v[164], v[163], v[162:160], v[159:96], v[95:32]);
         chk(status == v[31:0], $sformatf("R3..R10 vector %0d", i), status, v[31:0]);
      end

      // R2 done pulse and idle hold
      do_reset();
      @(negedge clk);
      issue(2'd0, 2'd0, 1'b0, 1'b0, 3'd0, {32'h0, S1}, {32'h0, S1});
      chk(done == 1'b1, "R2 done high", {31'h0, done}, 32'h1);
      opnd_a = {32'h0, S2};
      @(negedge clk);
      chk(done == 1'b0, "R2 done one cycle", {31'h0, done}, 32'h0);
      @(negedge clk);
      chk(status == 32'h0080_0000, "R2 no change without start", status, 32'h0080_0000);

      // R3 neighbours preserved, a bit can be cleared
      issue(2'd0, 2'd0, 1'b0, 1'b0, 3'd1, {32'h0, S1}, {32'h0, S1});
      chk(status == 32'h0280_0000, "R3 keep other bit", status, 32'h0280_0000);
      issue(2'd0, 2'd0, 1'b0, 1'b0, 3'd0, {32'h0, S1}, {32'h0, S2});
      chk(status == 32'h0200_0000, "R3 clear bit", status, 32'h0200_0000);

      // R8 trap keeps existing condition bit value
      issue(2'd0, 2'd0, 1'b0, 1'b1, 3'd1, {32'h0, SQN}, {32'h0, S1});
      chk(status == 32'h0201_0040, "R8 cc unchanged on trap", status, 32'h0201_0040);

      // R11 invalid bits stay set through ordinary compares
      issue(2'd0, 2'd1, 1'b0, 1'b0, 3'd1, {32'h0, S2}, {32'h0, S1});
      chk(status == 32'h0001_0040, "R11 sticky invalid", status, 32'h0001_0040);

      // R1 reset clears again
      do_reset();
      chk(status == 32'h0 && !done, "R1 reset after use", status, 32'h0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule